// File: doc/BRIEF.md
# Double-Buffered Nine-Bit Serial Transmitter

This block sends asynchronous serial frames of eight or nine data bits. A one-entry holding register sits in front of a shift register, so software can stage the next byte while the current frame is still on the line. When the shifter finishes a frame and the holding register is full, the next frame starts on the very next bit period with no idle gap. A clock divider inside the block sets the bit time.

Software uses two write strobes. One loads a byte into the holding register. The other updates the control fields: the nine-bit mode, the ninth-bit value, the output polarity and the bit-period divisor. The mode and the ninth bit are captured when a byte moves from the holding register into the shifter. The polarity and the divisor are applied only while the line is idle. A control write therefore never disturbs the timing of a frame already on the line.

Two flags guide the writer. `hold_empty` means a new byte may be written. `shift_empty` means nothing is being shifted out. A sticky `overrun` flag records a byte write that was refused.

Top module: `ser9_tx`

## Requirements
- R1: A frame is a start bit (0), then data bits 0 to 7 with bit 0 first, then a stop bit (1), all before inversion. Each bit lasts `ctrl_div + 1` clock cycles, using the divisor in force when the frame starts.
- R2: When the frame's nine-bit mode is set (`ctrl_nine` = 1), the value of `ctrl_bit9` is sent as an extra bit between data bit 7 and the stop bit. The frame then has 11 bits instead of 10.
- R3: The mode and the ninth-bit value are sampled when the byte moves into the shifter. A control write made after that moment applies only to later frames.
- R4: An accepted byte write drives `hold_empty` low at the next clock edge. `hold_empty` rises at the edge where the byte moves into the shifter. When the shifter is idle, that is one clock after the write was accepted.
- R5: `shift_empty` is 0 from the edge that starts a frame through the last clock of its stop bit, with no interruption while frames follow back to back. At all other times it is 1.
- R6: A control write while a frame is in flight does not change that frame's bit timing or polarity. A new divisor and a new polarity take effect only while the line is idle.
- R7: If the holding register is full when a stop bit ends, the next start bit begins on the following clock, with no idle period between the frames.
- R8: A byte written in the first cycle in which `shift_empty` has just risen is sent as a complete, correct frame.
- R9: With `ctrl_invert` = 1, every bit of `tx_out` is inverted, including the idle level, which becomes 0.
- R10: A byte write while `hold_empty` is 0 is discarded and sets `overrun` to 1. A control write clears `overrun`, unless a discarded write happens in the same cycle, in which case the flag stays set.
- R11: After reset, `tx_out` is 1, `hold_empty` is 1, `shift_empty` is 1 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_we | input | 1 | Byte write strobe for the holding register |
| data_in | input | 8 | Byte to transmit |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_nine | input | 1 | Nine-bit frame mode |
| ctrl_bit9 | input | 1 | Ninth data bit value |
| ctrl_invert | input | 1 | Output polarity inversion |
| ctrl_div | input | DIV_W | Bit period minus one, in clock cycles |
| tx_out | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | No frame is being shifted out |
| overrun | output | 1 | Sticky flag for a discarded byte write |

## Verification
A byte accepted at a clock edge reaches the shifter at the next edge when the line is idle. Its start bit is visible from that edge on, and each bit then holds for exactly `ctrl_div + 1` cycles. The bench waits for the transfer edge and then samples `tx_out` and `shift_empty` at every falling edge of the whole frame. Each sample is compared with the bit that cycle index divided by the period selects from an expected bit list built arithmetically. Flag checks are taken at the falling edge after the edge at which each flag is due: one cycle after a write for `hold_empty` and `overrun`, and one cycle after the last stop-bit clock for `shift_empty`.

// File: rtl/ser9_tx_pkg.sv
// Package: shared constants and frame construction for the nine-bit transmitter.
// Assumes frames carry one start bit, one stop bit and eight or nine data bits.
package ser9_tx_pkg;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 3;   // start + data + ninth + stop
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef logic [FRAME_BITS-1:0] frame_t;

    // Build the pre-inversion frame, LSB transmitted first.
    function automatic frame_t build_frame(input logic [DATA_BITS-1:0] d,
                                           input logic nine,
                                           input logic b9);
        frame_t f;
        f = '1;
        f[0] = 1'b0;
        f[DATA_BITS:1] = d;
        f[DATA_BITS+1] = nine ? b9 : 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/ser9_ctrl_reg.sv
// Control register: holds the pending mode, ninth bit, polarity and divisor.
// Polarity and divisor are copied to their active copies only while idle,
// so writes during a frame never re-time or re-phase the line.
module ser9_ctrl_reg #(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_nine,
    input  logic             ctrl_bit9,
    input  logic             ctrl_invert,
    input  logic [DIV_W-1:0] ctrl_div,
    input  logic             busy,
    output logic             nine_q,
    output logic             bit9_q,
    output logic             inv_act,
    output logic [DIV_W-1:0] div_act,
    output logic             inv_use,
    output logic [DIV_W-1:0] div_use
);

    logic             inv_pend;
    logic [DIV_W-1:0] div_pend;

    // Select active settings: frozen while busy, follow pending while idle.
    always_comb begin
        inv_use = busy ? inv_act : inv_pend;
        div_use = busy ? div_act : div_pend;
    end

    // Capture control writes and track the active copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nine_q   <= 1'b0;
            bit9_q   <= 1'b0;
            inv_pend <= 1'b0;
            div_pend <= DIV_W'(DEF_DIV);
            inv_act  <= 1'b0;
            div_act  <= DIV_W'(DEF_DIV);
        end else begin
            if (ctrl_we) begin
                nine_q   <= ctrl_nine;
                bit9_q   <= ctrl_bit9;
                inv_pend <= ctrl_invert;
                div_pend <= ctrl_div;
            end
            inv_act <= inv_use;
            div_act <= div_use;
        end
    end

endmodule

// File: rtl/ser9_baud_gen.sv
// Bit-period divider: emits one tick every (reload+1) clocks while running.
// Restart realigns the phase to the start of a new frame; nothing else does.
module ser9_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Tick on the last clock of each bit period.
    always_comb tick = run && (cnt == '0);

    // Count down, reload at the period end or at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= reload;
        end else if (run) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ser9_hold_reg.sv
// One-entry holding register with a full flag and a sticky overrun flag.
// Assumes the shifter takes the entry only while it is full.
module ser9_hold_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_we,
    input  logic [DW-1:0] data_in,
    input  logic          take,
    input  logic          ctrl_we,
    output logic [DW-1:0] data_q,
    output logic          full,
    output logic          overrun
);

    logic accept;
    logic reject;

    // Classify a write as accepted or discarded.
    always_comb begin
        accept = data_we && !full;
        reject = data_we && full;
    end

    // Hold the staged byte and its occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (accept) begin
            full   <= 1'b1;
            data_q <= data_in;
        end
    end

    // Sticky overrun: a discard sets it, a control write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (reject) begin
            overrun <= 1'b1;
        end else if (ctrl_we) begin
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/ser9_shifter.sv
// Frame shifter: loads a frame from the holding register, shifts one bit
// per tick, and chains into the next frame with no gap if one is waiting.
// Assumes tick is asserted only while busy.
module ser9_shifter
    import ser9_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 full,
    input  logic [DATA_BITS-1:0] hold_data,
    input  logic                 nine,
    input  logic                 bit9,
    input  logic                 tick,
    output logic                 take,
    output logic                 busy,
    output logic                 line
);

    frame_t           sr;
    logic [CNT_W-1:0] left;
    logic             last;

    // Decide when a staged byte moves into the shifter.
    always_comb begin
        last = (left == CNT_W'(1));
        take = full && (!busy || (tick && last));
        line = busy ? sr[0] : 1'b1;
    end

    // Load, shift and retire frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sr   <= '1;
            left <= '0;
        end else if (take) begin
            busy <= 1'b1;
            sr   <= build_frame(hold_data, nine, bit9);
            left <= nine ? CNT_W'(FRAME_BITS) : CNT_W'(FRAME_BITS - 1);
        end else if (busy && tick) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                sr   <= {1'b1, sr[FRAME_BITS-1:1]};
                left <= left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/ser9_tx.sv
// Top: double-buffered asynchronous transmitter with 8/9-bit frames,
// per-frame ninth-bit capture, idle-only divisor/polarity updates and a
// polarity-invert option. Synchronous active-low reset.
module ser9_tx
    import ser9_tx_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_we,
    input  logic [DATA_BITS-1:0] data_in,
    input  logic                 ctrl_we,
    input  logic                 ctrl_nine,
    input  logic                 ctrl_bit9,
    input  logic                 ctrl_invert,
    input  logic [DIV_W-1:0]     ctrl_div,
    output logic                 tx_out,
    output logic                 hold_empty,
    output logic                 shift_empty,
    output logic                 overrun
);

    logic                 nine_q;
    logic                 bit9_q;
    logic                 inv_act;
    logic [DIV_W-1:0]     div_act;
    logic                 inv_use;
    logic [DIV_W-1:0]     div_use;
    logic                 busy;
    logic                 take;
    logic                 tick;
    logic                 full;
    logic                 line;
    logic [DATA_BITS-1:0] hold_data;

    ser9_ctrl_reg #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .ctrl_nine(ctrl_nine), .ctrl_bit9(ctrl_bit9),
        .ctrl_invert(ctrl_invert), .ctrl_div(ctrl_div), .busy(busy),
        .nine_q(nine_q), .bit9_q(bit9_q), .inv_act(inv_act),
        .div_act(div_act), .inv_use(inv_use), .div_use(div_use)
    );

    ser9_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .restart(take), .run(busy),
        .reload(div_use), .tick(tick)
    );

    ser9_hold_reg #(.DW(DATA_BITS)) u_hold (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_in(data_in),
        .take(take), .ctrl_we(ctrl_we), .data_q(hold_data),
        .full(full), .overrun(overrun)
    );

    ser9_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .full(full), .hold_data(hold_data),
        .nine(nine_q), .bit9(bit9_q), .tick(tick), .take(take),
        .busy(busy), .line(line)
    );

    // Drive the line and status flags.
    always_comb begin
        tx_out      = line ^ inv_use;
        hold_empty  = !full;
        shift_empty = !busy;
    end

endmodule

// File: rtl/ser9_tx_chk.sv
// Checker: temporal properties of the transmitter, bound to ser9_tx.
module ser9_tx_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_we,
    input logic             ctrl_we,
    input logic             hold_empty,
    input logic             shift_empty,
    input logic             overrun,
    input logic             tx_out,
    input logic             inv_act,
    input logic [DIV_W-1:0] div_act
);

    p_hold_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && hold_empty) |=> !hold_empty);

    p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !hold_empty) |=> overrun);

    p_overrun_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !(data_we && !hold_empty)) |=> !overrun);

    p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> (tx_out == inv_act));

    p_transfer_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !shift_empty);

    p_div_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_empty && $past(!shift_empty)) |-> $stable(div_act));

endmodule

bind ser9_tx ser9_tx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .ctrl_we(ctrl_we),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .overrun(overrun),
    .tx_out(tx_out), .inv_act(inv_act), .div_act(div_act)
);

// File: tb/ser9_tx_tb.sv
module ser9_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_we = 1'b0;
    logic [7:0]       data_in = '0;
    logic             ctrl_we = 1'b0;
    logic             ctrl_nine = 1'b0;
    logic             ctrl_bit9 = 1'b0;
    logic             ctrl_invert = 1'b0;
    logic [DIV_W-1:0] ctrl_div = '0;
    logic             tx_out;
    logic             hold_empty;
    logic             shift_empty;
    logic             overrun;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  exp_bits [0:63];
    int  exp_len  = 0;
    int  period   = 1;
    bit  he_first = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser9_tx #(.DIV_W(DIV_W), .DEF_DIV(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_in(data_in),
        .ctrl_we(ctrl_we), .ctrl_nine(ctrl_nine), .ctrl_bit9(ctrl_bit9),
        .ctrl_invert(ctrl_invert), .ctrl_div(ctrl_div), .tx_out(tx_out),
        .hold_empty(hold_empty), .shift_empty(shift_empty), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr_ctrl(input bit nine, input bit b9, input bit inv, input int dv);
        @(posedge clk); #1;
        ctrl_we = 1'b1; ctrl_nine = nine; ctrl_bit9 = b9;
        ctrl_invert = inv; ctrl_div = DIV_W'(dv);
        @(posedge clk); #1;
        ctrl_we = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(posedge clk); #1;
        data_we = 1'b1; data_in = d;
        @(posedge clk); #1;
        data_we = 1'b0;
    endtask

    // Append one frame's bits (before inversion) to the expected list.
    task automatic push_frame(input logic [7:0] d, input bit nine, input bit b9);
        exp_bits[exp_len] = 1'b0; exp_len++;
        for (int i = 0; i < 8; i++) begin
            exp_bits[exp_len] = d[i]; exp_len++;
        end
        if (nine) begin
            exp_bits[exp_len] = b9; exp_len++;
        end
        exp_bits[exp_len] = 1'b1; exp_len++;
    endtask

    // Wait for the transfer edge, then sample each clock of the frame(s).
    task automatic mon(input bit inv, input string req);
        int errs = 0;
        int a = 0;
        int e = 0;
        @(posedge clk);
        for (int c = 0; c < exp_len * period; c++) begin
            @(negedge clk);
            if (c == 0) he_first = hold_empty;
            if (tx_out !== (exp_bits[c / period] ^ inv) || shift_empty !== 1'b0) begin
                if (errs == 0) begin
                    a = {shift_empty, tx_out};
                    e = {1'b0, exp_bits[c / period] ^ inv};
                end
                errs++;
            end
        end
        chk(errs == 0, req, a, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [0:5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(tx_out === 1'b1, "R11 tx_out", tx_out, 1);
        chk(hold_empty === 1'b1, "R11 hold_empty", hold_empty, 1);
        chk(shift_empty === 1'b1, "R11 shift_empty", shift_empty, 1);
        chk(overrun === 1'b0, "R11 overrun", overrun, 0);

        // Sweep: R1 R2 R4 R5 R9 over divisor, mode, ninth bit, polarity, data
        for (int v = 0; v < 4; v += (v == 0) ? 1 : 2) begin
            for (int nm = 0; nm < 2; nm++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int iv = 0; iv < 2; iv++) begin
                        for (int p = 0; p < 6; p++) begin
                            wr_ctrl(nm[0], b[0], iv[0], v);
                            @(negedge clk);
                            chk(tx_out === !iv[0], "R9 idle level", tx_out, !iv[0]);
                            exp_len = 0;
                            period = v + 1;
                            push_frame(pats[p], nm[0], b[0]);
                            wr_byte(pats[p]);
                            chk(hold_empty === 1'b0, "R4 full after write", hold_empty, 0);
                            mon(iv[0], nm[0] ? "R2 nine-bit frame" : "R1 eight-bit frame");
                            chk(he_first === 1'b1, "R4 empty at transfer", he_first, 1);
                            @(posedge clk);
                            @(negedge clk);
                            chk(shift_empty === 1'b1, "R5 empty after stop", shift_empty, 1);
                        end
                    end
                end
            end
        end

        // R3 R6 R7: back-to-back frames, control rewritten during the first
        wr_ctrl(1'b1, 1'b0, 1'b0, 2);
        exp_len = 0;
        period = 3;
        push_frame(8'h3C, 1'b1, 1'b0);
        push_frame(8'hC3, 1'b1, 1'b1);
        wr_byte(8'h3C);
        fork
            mon(1'b0, "R7 R3 R6 chained frames");
            begin
                wr_byte(8'hC3);
                repeat (3) @(posedge clk);
                #1;
                ctrl_we = 1'b1; ctrl_nine = 1'b1; ctrl_bit9 = 1'b1;
                ctrl_invert = 1'b1; ctrl_div = DIV_W'(0);
                @(posedge clk); #1;
                ctrl_we = 1'b0;
            end
        join

        // R8: write on the cycle shift_empty has just risen; new settings apply
        wr_byte(8'h96);
        chk(shift_empty === 1'b1, "R8 idle at write", shift_empty, 1);
        chk(tx_out === 1'b0, "R9 inverted idle", tx_out, 0);
        exp_len = 0;
        period = 1;
        push_frame(8'h96, 1'b1, 1'b1);
        mon(1'b1, "R8 R6 frame after rise");

        // R10: third write while full is discarded and flagged
        wr_ctrl(1'b0, 1'b0, 1'b0, 0);
        chk(overrun === 1'b0, "R10 cleared", overrun, 0);
        exp_len = 0;
        period = 1;
        push_frame(8'h11, 1'b0, 1'b0);
        push_frame(8'h22, 1'b0, 1'b0);
        wr_byte(8'h11);
        fork
            mon(1'b0, "R10 R7 kept frames");
            begin
                wr_byte(8'h22);
                wr_byte(8'h33);
                chk(overrun === 1'b1, "R10 set on discard", overrun, 1);
            end
        join
        @(posedge clk);
        @(negedge clk);
        chk(shift_empty === 1'b1 && tx_out === 1'b1, "R10 discarded byte not sent",
            {shift_empty, tx_out}, 3);
        chk(overrun === 1'b1, "R10 sticky", overrun, 1);
        wr_ctrl(1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        chk(overrun === 1'b0, "R10 clear by ctrl write", overrun, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule